// File: doc/BRIEF.md
# Memory Request Router with Outstanding Counters

This block receives memory requests that have already been translated: loads, stores and atomics. Each request carries an address space code and the ID of the wavefront slot that issued it. The router first decides whether the operation is allowed in that space. A legal request is placed in one of two small queues, one feeding the global-memory pipe and one feeding the local shared-memory pipe. The router attaches a latency tag to the queued entry. The tag depends on both the operation and the target pipe.

For every wavefront slot the block keeps five counters: outstanding reads on the global pipe, outstanding writes on the global pipe, the same two for the local pipe, and a total. A completion port reports finished work and decrements the matching counters. An illegal request is consumed and dropped, and an error code is raised one cycle later. A query port returns the counters of any one slot. The memory behind the queues lies outside this block.

Top module: `mem_req_router`

## Requirements
- R1: Address space codes are 0 global, 1 spill, 2 private, 3 read-only and 4 shared. A legal request in space 4 is queued on the local pipe (`lq_*`). A legal request in spaces 0 to 3 is queued on the global pipe (`gq_*`). Either way the entry reaches the queue head the cycle after acceptance, carrying the request's op, wavefront and address.
- R2: The queued latency tag is 1 for global-pipe loads and stores, 24 for any local-pipe access, and 64 for a global-pipe atomic.
- R3: Op codes are 0 load, 1 store and 2 atomic. An accepted load adds one to the read counter of its pipe. An accepted store adds one to the write counter of its pipe. Every accepted request adds one to the slot's total. All of these are visible on the query port from the cycle after acceptance.
- R4: An accepted atomic adds one to both the read and the write counter of its pipe, and adds one to the total.
- R5: An atomic in any space other than global or shared is dropped. Dropped means it is not queued and no counter changes. `err_valid` pulses for one cycle the cycle after the request, with `err_code` = 1.
- R6: A store to the read-only space is dropped with `err_code` = 2. A load from the read-only space is legal and goes to the global pipe.
- R7: A request with an address space code above 4, or with op code 3, is dropped with `err_code` = 3. An illegal request is always consumed, so `req_ready` stays high for it.
- R8: Each queue holds Q_DEPTH entries in arrival order. `req_ready` is low only when the presented request is legal and its own target queue is full; a full queue does not block requests bound for the other pipe. While `*_ready` is low, the queue head holds steady.
- R9: A completion names a slot, a pipe (0 global, 1 local) and the flags `cmp_rd` and `cmp_wr`. Each set flag takes one from the matching counter. The total loses one if either flag is set, so an atomic completes with both flags set.
- R10: A decrement of a counter that is already zero leaves it at zero and pulses `cnt_uflow` for one cycle on the following cycle.
- R11: When one cycle both adds to and takes from the same counter, the counter is left unchanged.
- R12: After reset every counter reads zero, both queues are empty, `req_ready` is high, and `err_valid` and `cnt_uflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request consumed this cycle when valid |
| req_op | input | 2 | Operation code |
| req_seg | input | 3 | Address space code |
| req_wf | input | WFW | Wavefront slot ID |
| req_addr | input | ADDR_W | Request address |
| err_valid | output | 1 | One-cycle pulse for a dropped illegal request |
| err_code | output | 2 | Reason for the drop |
| gq_valid | output | 1 | Global queue head present |
| gq_ready | input | 1 | Pop global queue head |
| gq_op | output | 2 | Head operation |
| gq_wf | output | WFW | Head wavefront slot |
| gq_lat | output | 7 | Head latency tag |
| gq_addr | output | ADDR_W | Head address |
| lq_valid | output | 1 | Local queue head present |
| lq_ready | input | 1 | Pop local queue head |
| lq_op | output | 2 | Head operation |
| lq_wf | output | WFW | Head wavefront slot |
| lq_lat | output | 7 | Head latency tag |
| lq_addr | output | ADDR_W | Head address |
| cmp_valid | input | 1 | Completion present |
| cmp_wf | input | WFW | Completing wavefront slot |
| cmp_pipe | input | 1 | Completing pipe |
| cmp_rd | input | 1 | Read part completed |
| cmp_wr | input | 1 | Write part completed |
| qry_wf | input | WFW | Slot whose counters are shown |
| qry_rd_glb | output | CNT_W | Outstanding global reads |
| qry_wr_glb | output | CNT_W | Outstanding global writes |
| qry_rd_lcl | output | CNT_W | Outstanding local reads |
| qry_wr_lcl | output | CNT_W | Outstanding local writes |
| qry_total | output | CNT_W | Outstanding requests in total |
| cnt_uflow | output | 1 | One-cycle pulse after a decrement at zero |

## Verification
The only combinational path from request to result is `req_ready`. The bench reads it one time step after it drives a request, before the clock edge that decides acceptance. Queue heads, counters, `err_valid` and `cnt_uflow` all pass through exactly one register. The bench therefore checks them at the falling edge that follows the accepting rising edge. That is the single cycle in which the two pulse outputs are high. The query port is combinational on the stored counters, so the bench sets `qry_wf` and reads the outputs a time step later within the same half cycle.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

    localparam int LAT_W     = 7;
    localparam int CNT_KINDS = 5;

    localparam logic [LAT_W-1:0] LAT_GLB_RW  = 7'd1;
    localparam logic [LAT_W-1:0] LAT_LCL     = 7'd24;
    localparam logic [LAT_W-1:0] LAT_GLB_ATM = 7'd64;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_ATOMIC = 2'd2
    } mem_op_e;

    typedef enum logic [2:0] {
        SP_GLOBAL   = 3'd0,
        SP_SPILL    = 3'd1,
        SP_PRIVATE  = 3'd2,
        SP_READONLY = 3'd3,
        SP_SHARED   = 3'd4
    } space_e;

    typedef enum logic {
        PIPE_GLB = 1'b0,
        PIPE_LCL = 1'b1
    } pipe_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_ATOM_SP  = 2'd1,
        ERR_ST_RO    = 2'd2,
        ERR_BAD_CODE = 2'd3
    } err_e;

    typedef struct packed {
        logic             legal;
        pipe_e            pipe;
        logic [LAT_W-1:0] lat;
        err_e             err;
    } route_t;

    // counter kinds inside one wavefront slot
    localparam int K_RD_GLB = 0;
    localparam int K_WR_GLB = 1;
    localparam int K_RD_LCL = 2;
    localparam int K_WR_LCL = 3;
    localparam int K_TOTAL  = 4;

    function automatic logic kind_hit(input int kind, input pipe_e p,
                                      input logic rd, input logic wr);
        logic hit;
        case (kind)
            K_RD_GLB: hit = (p == PIPE_GLB) && rd;
            K_WR_GLB: hit = (p == PIPE_GLB) && wr;
            K_RD_LCL: hit = (p == PIPE_LCL) && rd;
            K_WR_LCL: hit = (p == PIPE_LCL) && wr;
            default:  hit = rd || wr;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/mrr_decode.sv
module mrr_decode
    import mrr_pkg::*;
(
    input  logic [1:0] op,
    input  logic [2:0] sp,
    output route_t     route
);
    logic bad_code;
    logic atom_ok;

    assign bad_code = (op == 2'd3) || (sp > SP_SHARED);
    assign atom_ok  = (sp == SP_GLOBAL) || (sp == SP_SHARED);

    always_comb begin
        route.pipe  = (sp == SP_SHARED) ? PIPE_LCL : PIPE_GLB;
        route.legal = 1'b0;
        route.err   = ERR_NONE;
        if (route.pipe == PIPE_LCL) begin
            route.lat = LAT_LCL;
        end else if (op == OP_ATOMIC) begin
            route.lat = LAT_GLB_ATM;
        end else begin
            route.lat = LAT_GLB_RW;
        end

        if (bad_code) begin
            route.err = ERR_BAD_CODE;
        end else if ((op == OP_ATOMIC) && !atom_ok) begin
            route.err = ERR_ATOM_SP;
        end else if ((op == OP_STORE) && (sp == SP_READONLY)) begin
            route.err = ERR_ST_RO;
        end else begin
            route.legal = 1'b1;
        end
    end
endmodule

// File: rtl/mrr_fifo.sv
module mrr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign valid   = (fill != '0);
    assign full    = (fill == CW'(DEPTH));
    assign dout    = store[rp];
    assign do_push = push && !full;
    assign do_pop  = pop && valid;

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            if (do_push && !do_pop)      fill <= fill + 1'b1;
            else if (do_pop && !do_push) fill <= fill - 1'b1;
        end
    end
endmodule

// File: rtl/mrr_ctr_bank.sv
module mrr_ctr_bank
    import mrr_pkg::*;
#(
    parameter int WF_NUM = 4,
    parameter int CNT_W  = 6,
    localparam int WFW   = (WF_NUM > 1) ? $clog2(WF_NUM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [WFW-1:0]   inc_wf,
    input  pipe_e            inc_pipe,
    input  logic             inc_rd,
    input  logic             inc_wr,
    input  logic             dec_en,
    input  logic [WFW-1:0]   dec_wf,
    input  pipe_e            dec_pipe,
    input  logic             dec_rd,
    input  logic             dec_wr,
    input  logic [WFW-1:0]   qry_wf,
    output logic [CNT_W-1:0] qry_rd_glb,
    output logic [CNT_W-1:0] qry_wr_glb,
    output logic [CNT_W-1:0] qry_rd_lcl,
    output logic [CNT_W-1:0] qry_wr_lcl,
    output logic [CNT_W-1:0] qry_total,
    output logic             uflow
);
    logic [CNT_W-1:0]            cnt_q [WF_NUM][CNT_KINDS];
    logic [WF_NUM*CNT_KINDS-1:0] under;

    for (genvar w = 0; w < WF_NUM; w++) begin : g_wf
        for (genvar k = 0; k < CNT_KINDS; k++) begin : g_kind
            logic up, dn;
            assign up = inc_en && (inc_wf == WFW'(w)) &&
                        kind_hit(k, inc_pipe, inc_rd, inc_wr);
            assign dn = dec_en && (dec_wf == WFW'(w)) &&
                        kind_hit(k, dec_pipe, dec_rd, dec_wr);
            assign under[w*CNT_KINDS + k] = dn && !up && (cnt_q[w][k] == '0);

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q[w][k] <= '0;
                end else if (up && !dn) begin
                    cnt_q[w][k] <= cnt_q[w][k] + 1'b1;
                end else if (dn && !up && (cnt_q[w][k] != '0)) begin
                    cnt_q[w][k] <= cnt_q[w][k] - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) uflow <= 1'b0;
        else     uflow <= |under;
    end

    assign qry_rd_glb = cnt_q[qry_wf][K_RD_GLB];
    assign qry_wr_glb = cnt_q[qry_wf][K_WR_GLB];
    assign qry_rd_lcl = cnt_q[qry_wf][K_RD_LCL];
    assign qry_wr_lcl = cnt_q[qry_wf][K_WR_LCL];
    assign qry_total  = cnt_q[qry_wf][K_TOTAL];
endmodule

// File: rtl/mem_req_router.sv
module mem_req_router
    import mrr_pkg::*;
#(
    parameter int WF_NUM  = 4,
    parameter int CNT_W   = 6,
    parameter int Q_DEPTH = 4,
    parameter int ADDR_W  = 32,
    localparam int WFW    = (WF_NUM > 1) ? $clog2(WF_NUM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [2:0]        req_seg,
    input  logic [WFW-1:0]    req_wf,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              err_valid,
    output logic [1:0]        err_code,
    output logic              gq_valid,
    input  logic              gq_ready,
    output logic [1:0]        gq_op,
    output logic [WFW-1:0]    gq_wf,
    output logic [6:0]        gq_lat,
    output logic [ADDR_W-1:0] gq_addr,
    output logic              lq_valid,
    input  logic              lq_ready,
    output logic [1:0]        lq_op,
    output logic [WFW-1:0]    lq_wf,
    output logic [6:0]        lq_lat,
    output logic [ADDR_W-1:0] lq_addr,
    input  logic              cmp_valid,
    input  logic [WFW-1:0]    cmp_wf,
    input  logic              cmp_pipe,
    input  logic              cmp_rd,
    input  logic              cmp_wr,
    input  logic [WFW-1:0]    qry_wf,
    output logic [CNT_W-1:0]  qry_rd_glb,
    output logic [CNT_W-1:0]  qry_wr_glb,
    output logic [CNT_W-1:0]  qry_rd_lcl,
    output logic [CNT_W-1:0]  qry_wr_lcl,
    output logic [CNT_W-1:0]  qry_total,
    output logic              cnt_uflow
);
    localparam int QW    = 2 + WFW + LAT_W + ADDR_W;
    localparam int NPIPE = 2;

    route_t          route;
    logic [NPIPE-1:0] q_push, q_pop, q_valid, q_full;
    logic [QW-1:0]   q_din;
    logic [QW-1:0]   q_dout [NPIPE];
    logic            tgt_full, accept;
    logic            acc_rd, acc_wr;

    mrr_decode u_decode (
        .op    (req_op),
        .sp    (req_seg),
        .route (route)
    );

    assign tgt_full  = q_full[route.pipe];
    assign req_ready = !route.legal || !tgt_full;
    assign accept    = req_valid && route.legal && !tgt_full;
    assign acc_rd    = (req_op == OP_LOAD)  || (req_op == OP_ATOMIC);
    assign acc_wr    = (req_op == OP_STORE) || (req_op == OP_ATOMIC);
    assign q_din     = {req_op, req_wf, route.lat, req_addr};
    assign q_pop     = {lq_ready, gq_ready};

    for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
        assign q_push[p] = accept && (route.pipe == pipe_e'(p));
        mrr_fifo #(.W(QW), .DEPTH(Q_DEPTH)) u_q (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[p]),
            .din   (q_din),
            .pop   (q_pop[p]),
            .dout  (q_dout[p]),
            .valid (q_valid[p]),
            .full  (q_full[p])
        );
    end

    assign gq_valid = q_valid[PIPE_GLB];
    assign {gq_op, gq_wf, gq_lat, gq_addr} = q_dout[PIPE_GLB];
    assign lq_valid = q_valid[PIPE_LCL];
    assign {lq_op, lq_wf, lq_lat, lq_addr} = q_dout[PIPE_LCL];

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_valid <= req_valid && !route.legal;
            err_code  <= (req_valid && !route.legal) ? route.err : ERR_NONE;
        end
    end

    mrr_ctr_bank #(.WF_NUM(WF_NUM), .CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .inc_en     (accept),
        .inc_wf     (req_wf),
        .inc_pipe   (route.pipe),
        .inc_rd     (acc_rd),
        .inc_wr     (acc_wr),
        .dec_en     (cmp_valid),
        .dec_wf     (cmp_wf),
        .dec_pipe   (pipe_e'(cmp_pipe)),
        .dec_rd     (cmp_rd),
        .dec_wr     (cmp_wr),
        .qry_wf     (qry_wf),
        .qry_rd_glb (qry_rd_glb),
        .qry_wr_glb (qry_wr_glb),
        .qry_rd_lcl (qry_rd_lcl),
        .qry_wr_lcl (qry_wr_lcl),
        .qry_total  (qry_total),
        .uflow      (cnt_uflow)
    );
endmodule

// File: rtl/mrr_chk.sv
module mrr_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [2:0]        req_seg,
    input logic              err_valid,
    input logic [1:0]        err_code,
    input logic              gq_valid,
    input logic              gq_ready,
    input logic [ADDR_W-1:0] gq_addr,
    input logic              lq_valid,
    input logic              cmp_valid,
    input logic              cnt_uflow
);
    // R8
    gq_head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gq_valid && !gq_ready) |=> (gq_valid && $stable(gq_addr)));

    // R1
    shared_route_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_seg == 3'd4 && req_op != 2'd3) |=> lq_valid);

    // R5
    err_origin_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> ($past(req_valid) && err_code != 2'd0));

    // R7
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_seg > 3'd4) |=> (err_valid && err_code == 2'd3));

    // R8
    stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |-> (gq_valid || lq_valid));

    // R10
    uflow_origin_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_uflow |-> $past(cmp_valid));
endmodule

bind mem_req_router mrr_chk #(.ADDR_W(ADDR_W)) u_mrr_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_seg   (req_seg),
    .err_valid (err_valid),
    .err_code  (err_code),
    .gq_valid  (gq_valid),
    .gq_ready  (gq_ready),
    .gq_addr   (gq_addr),
    .lq_valid  (lq_valid),
    .cmp_valid (cmp_valid),
    .cnt_uflow (cnt_uflow)
);

// File: tb/mem_req_router_bench.sv
module mem_req_router_bench;
    localparam int WFN = 4;
    localparam int CW  = 6;
    localparam int AW  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_op = '0;
    logic [2:0] req_seg = '0;
    logic [1:0] req_wf = '0;
    logic [AW-1:0] req_addr = '0;
    logic err_valid;
    logic [1:0] err_code;
    logic gq_valid, gq_ready = 1'b0, lq_valid, lq_ready = 1'b0;
    logic [1:0] gq_op, lq_op, gq_wf, lq_wf;
    logic [6:0] gq_lat, lq_lat;
    logic [AW-1:0] gq_addr, lq_addr;
    logic cmp_valid = 1'b0, cmp_pipe = 1'b0, cmp_rd = 1'b0, cmp_wr = 1'b0;
    logic [1:0] cmp_wf = '0, qry_wf = '0;
    logic [CW-1:0] qry_rd_glb, qry_wr_glb, qry_rd_lcl, qry_wr_lcl, qry_total;
    logic cnt_uflow;

    int n_chk = 0, n_err = 0;
    int m_rg[WFN], m_wg[WFN], m_rl[WFN], m_wl[WFN], m_tot[WFN];

    always #5 clk = ~clk;

    mem_req_router #(.WF_NUM(WFN), .CNT_W(CW), .Q_DEPTH(4), .ADDR_W(AW)) u_mem_req_router (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_seg(req_seg), .req_wf(req_wf), .req_addr(req_addr),
        .err_valid(err_valid), .err_code(err_code),
        .gq_valid(gq_valid), .gq_ready(gq_ready), .gq_op(gq_op), .gq_wf(gq_wf),
        .gq_lat(gq_lat), .gq_addr(gq_addr),
        .lq_valid(lq_valid), .lq_ready(lq_ready), .lq_op(lq_op), .lq_wf(lq_wf),
        .lq_lat(lq_lat), .lq_addr(lq_addr),
        .cmp_valid(cmp_valid), .cmp_wf(cmp_wf), .cmp_pipe(cmp_pipe),
        .cmp_rd(cmp_rd), .cmp_wr(cmp_wr),
        .qry_wf(qry_wf), .qry_rd_glb(qry_rd_glb), .qry_wr_glb(qry_wr_glb),
        .qry_rd_lcl(qry_rd_lcl), .qry_wr_lcl(qry_wr_lcl), .qry_total(qry_total),
        .cnt_uflow(cnt_uflow)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_wf(input int wf, input string tag);
        qry_wf = wf[1:0];
        #1;
        chk({tag, " rd_glb"}, qry_rd_glb, m_rg[wf]);
        chk({tag, " wr_glb"}, qry_wr_glb, m_wg[wf]);
        chk({tag, " rd_lcl"}, qry_rd_lcl, m_rl[wf]);
        chk({tag, " wr_lcl"}, qry_wr_lcl, m_wl[wf]);
        chk({tag, " total"},  qry_total,  m_tot[wf]);
    endtask

    function automatic void mdl_add(input int op, input int lcl, input int wf);
        if (op != 1) begin if (lcl != 0) m_rl[wf]++; else m_rg[wf]++; end
        if (op != 0) begin if (lcl != 0) m_wl[wf]++; else m_wg[wf]++; end
        m_tot[wf]++;
    endfunction

    task automatic send(input int op, input int sp, input int wf, input logic [AW-1:0] a);
        @(negedge clk);
        req_op = op[1:0]; req_seg = sp[2:0]; req_wf = wf[1:0]; req_addr = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pop_g();
        gq_ready = 1'b1; @(negedge clk); gq_ready = 1'b0;
    endtask

    task automatic pop_l();
        lq_ready = 1'b1; @(negedge clk); lq_ready = 1'b0;
    endtask

    // R1 R2 R3 R4: legal request lands on the expected pipe with the expected tag
    task automatic t_route(input int op, input int sp, input int wf,
                           input logic [AW-1:0] a, input int lat, input string tag);
        int lcl;
        lcl = (sp == 4) ? 1 : 0;
        send(op, sp, wf, a);
        mdl_add(op, lcl, wf);
        chk({tag, " err_valid"}, err_valid, 0);
        if (lcl != 0) begin
            chk({tag, " R1 lq_valid"}, lq_valid, 1);
            chk({tag, " R1 gq_valid"}, gq_valid, 0);
            chk({tag, " R1 lq_op"}, lq_op, op);
            chk({tag, " R1 lq_wf"}, lq_wf, wf);
            chk({tag, " R1 lq_addr"}, lq_addr, a);
            chk({tag, " R2 lq_lat"}, lq_lat, lat);
        end else begin
            chk({tag, " R1 gq_valid"}, gq_valid, 1);
            chk({tag, " R1 lq_valid"}, lq_valid, 0);
            chk({tag, " R1 gq_op"}, gq_op, op);
            chk({tag, " R1 gq_wf"}, gq_wf, wf);
            chk({tag, " R1 gq_addr"}, gq_addr, a);
            chk({tag, " R2 gq_lat"}, gq_lat, lat);
        end
        chk_wf(wf, {tag, " R3 counters"});
        if (lcl != 0) pop_l(); else pop_g();
    endtask

    // R5 R6 R7: illegal request is consumed and dropped
    task automatic t_bad(input int op, input int sp, input int wf, input int code, input string tag);
        @(negedge clk);
        req_op = op[1:0]; req_seg = sp[2:0]; req_wf = wf[1:0]; req_addr = 32'hDEAD; req_valid = 1'b1;
        #1;
        chk({tag, " R7 ready for illegal"}, req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " err_valid"}, err_valid, 1);
        chk({tag, " err_code"}, err_code, code);
        chk({tag, " gq untouched"}, gq_valid, 0);
        chk({tag, " lq untouched"}, lq_valid, 0);
        chk_wf(wf, {tag, " counters unchanged"});
        @(negedge clk);
        chk({tag, " err pulse ends"}, err_valid, 0);
    endtask

    // R9 R10: completion
    task automatic t_cmp(input int wf, input int lcl, input int rd, input int wr, input string tag);
        int und;
        und = 0;
        @(negedge clk);
        cmp_valid = 1'b1; cmp_wf = wf[1:0]; cmp_pipe = lcl[0]; cmp_rd = rd[0]; cmp_wr = wr[0];
        @(negedge clk);
        cmp_valid = 1'b0;
        if (rd != 0) begin
            if (lcl != 0) begin if (m_rl[wf] == 0) und = 1; else m_rl[wf]--; end
            else          begin if (m_rg[wf] == 0) und = 1; else m_rg[wf]--; end
        end
        if (wr != 0) begin
            if (lcl != 0) begin if (m_wl[wf] == 0) und = 1; else m_wl[wf]--; end
            else          begin if (m_wg[wf] == 0) und = 1; else m_wg[wf]--; end
        end
        if (rd != 0 || wr != 0) begin
            if (m_tot[wf] == 0) und = 1; else m_tot[wf]--;
        end
        chk({tag, " R10 uflow"}, cnt_uflow, und);
        chk_wf(wf, {tag, " R9 counters"});
    endtask

    task automatic t_reset();
        for (int w = 0; w < WFN; w++) chk_wf(w, "R12 reset");
        chk("R12 req_ready", req_ready, 1);
        chk("R12 gq_valid", gq_valid, 0);
        chk("R12 lq_valid", lq_valid, 0);
        chk("R12 err_valid", err_valid, 0);
        chk("R12 cnt_uflow", cnt_uflow, 0);
    endtask

    // R8: depth, per-target stall and order
    task automatic t_fill();
        for (int i = 0; i < 4; i++) begin
            send(0, 0, 0, 32'h40 + 32'(i));
            mdl_add(0, 0, 0);
        end
        @(negedge clk);
        req_op = 2'd0; req_seg = 3'd1; req_wf = 2'd0; req_addr = 32'h99; req_valid = 1'b1;
        #1;
        chk("R8 ready low when global full", req_ready, 0);
        req_seg = 3'd4; req_addr = 32'h77;
        #1;
        chk("R8 ready high for other pipe", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        mdl_add(0, 1, 0);
        chk("R8 local accepted", lq_valid, 1);
        chk("R8 local addr", lq_addr, 32'h77);
        chk_wf(0, "R8 counters after fill");
        @(negedge clk);
        req_op = 2'd1; req_seg = 3'd2; req_wf = 2'd0; req_addr = 32'h98; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk_wf(0, "R8 refused store not counted");
        for (int i = 0; i < 4; i++) begin
            chk("R8 order", gq_addr, 32'h40 + 32'(i));
            pop_g();
        end
        chk("R8 global drained", gq_valid, 0);
        pop_l();
        chk("R8 local drained", lq_valid, 0);
    endtask

    // R11: simultaneous increment and decrement
    task automatic t_same_cycle();
        @(negedge clk);
        req_op = 2'd0; req_seg = 3'd0; req_wf = 2'd2; req_addr = 32'h555; req_valid = 1'b1;
        cmp_valid = 1'b1; cmp_wf = 2'd2; cmp_pipe = 1'b0; cmp_rd = 1'b1; cmp_wr = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; cmp_valid = 1'b0;
        chk("R11 entry queued", gq_addr, 32'h555);
        chk("R11 no uflow", cnt_uflow, 0);
        chk_wf(2, "R11 counters unchanged");
        pop_g();
    endtask

    initial begin
        for (int w = 0; w < WFN; w++) begin
            m_rg[w] = 0; m_wg[w] = 0; m_rl[w] = 0; m_wl[w] = 0; m_tot[w] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_route(0, 0, 1, 32'h100, 1,  "glb load");
        t_route(0, 1, 0, 32'h104, 1,  "spill load");
        t_route(1, 2, 0, 32'h108, 1,  "private store");
        t_route(0, 3, 2, 32'h10C, 1,  "R6 readonly load");
        t_route(0, 4, 1, 32'h200, 24, "shared load");
        t_route(1, 4, 1, 32'h204, 24, "shared store");
        t_route(2, 0, 2, 32'h300, 64, "R4 glb atomic");
        t_route(2, 4, 3, 32'h304, 24, "R4 shared atomic");
        t_bad(2, 1, 0, 1, "R5 atomic spill");
        t_bad(2, 2, 1, 1, "R5 atomic private");
        t_bad(2, 3, 2, 1, "R5 atomic readonly");
        t_bad(1, 3, 3, 2, "R6 store readonly");
        t_bad(0, 5, 0, 3, "R7 space 5");
        t_bad(1, 7, 1, 3, "R7 space 7");
        t_bad(3, 0, 2, 3, "R7 op 3");
        t_fill();
        t_cmp(1, 0, 1, 0, "glb read done");
        t_cmp(1, 1, 0, 1, "lcl write done");
        t_cmp(2, 0, 1, 1, "glb atomic done");
        t_cmp(3, 1, 1, 1, "lcl atomic done");
        t_cmp(3, 0, 1, 0, "underflow");
        t_same_cycle();
        for (int w = 0; w < WFN; w++) chk_wf(w, "final counters");
        finish_run();
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule